// File: doc/BRIEF.md
# Code-Selected Reference Divider

This block divides an incoming reference clock by one of eight fixed ratios and emits a single-cycle pulse at the end of every divide period. The pulse train feeds the reference side of a phase detector as its comparison frequency. A 3-bit code picks the ratio from a fixed table. Seven entries of that table are powers of two. One entry is the non-power-of-two value 2410.

A 14-bit down-counter holds the remaining count of the current period. When it reaches zero, the output pulses for that cycle. On the next rising edge the counter reloads from the table entry that the select code names at that moment. A code change made in the middle of a period therefore has no effect until the period finishes. The reset is synchronous and active low. It loads the counter from the currently selected entry, so the first period after reset has the full selected length.

Top module: `refdiv`

## Requirements
- R1: The select code `ratio_sel` maps to the divide ratio as follows: 0→8, 1→128, 2→256, 3→512, 4→1024, 5→2048, 6→2410, 7→8192. No other ratio is ever produced.
- R2: While the select code is held constant, consecutive output pulses are exactly the selected ratio of clock cycles apart, period after period.
- R3: Every output pulse is high for exactly one clock cycle.
- R4: A select change made partway through a period does not alter that period. The period ends at the old ratio, and the following period uses the new ratio.
- R5: If the select code is changed and then restored before the terminal count, the running period and the next one both keep the original ratio.
- R6: While `rst_n` is low, the output stays low after the first clock edge. After release with ratio R selected, the first pulse is high in the R-th cycle, which is R-1 rising edges after the release.
- R7: A select code presented during the pulse cycle governs the very next period.
- R8: With code 6 and a 10.0417 MHz reference, the pulse rate is within 0.5 Hz of 4166.7 Hz.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock to be divided |
| rst_n | input | 1 | Synchronous active-low reset; loads the selected ratio |
| ratio_sel | input | 3 | Divide-ratio select code |
| ref_pulse_o | output | 1 | One-cycle pulse at the end of each divide period |

## Verification
Several properties are checked on every clock by the assertions: the single-cycle width of the pulse, the down-count step between pulses, the reload value taken from the code sampled on the terminal edge, quiet output under reset, and a maximum spacing between pulses. Other behaviours can only be shown by the bench's scenarios. These are the exact length of each period for all eight codes, the length of the first period after reset, a mid-period code change taking effect one period late, a change that is undone before the terminal count having no effect, and the resulting comparison frequency for the 2410 ratio.

// File: rtl/refdiv_pkg.sv
// Package: shared constants and the ratio table function for the reference divider.
// Assumes: a select code of SEL_W bits and ratios that fit in CNT_W bits.
package refdiv_pkg;

    localparam int SEL_W   = 3;
    localparam int CNT_W   = 14;
    localparam int N_RATIO = 1 << SEL_W;

    // Divide ratio for a select code; 6 is the single non-power-of-two entry.
    function automatic int unsigned ratio_of(input int unsigned code);
        case (code)
            0:       ratio_of = 8;
            1:       ratio_of = 128;
            2:       ratio_of = 256;
            3:       ratio_of = 512;
            4:       ratio_of = 1024;
            5:       ratio_of = 2048;
            6:       ratio_of = 2410;
            default: ratio_of = 8192;
        endcase
    endfunction

endpackage

// File: rtl/refdiv_ratio_lut.sv
// Module: maps the select code to a reload value, which is the ratio minus one.
// Assumes: every ratio returned by refdiv_pkg::ratio_of is between 2 and 2**CNT_W.
module refdiv_ratio_lut #(
    parameter int SEL_W = refdiv_pkg::SEL_W,
    parameter int CNT_W = refdiv_pkg::CNT_W
) (
    input  logic [SEL_W-1:0] sel_i,
    output logic [CNT_W-1:0] reload_o
);

    localparam int N_ENT = 1 << SEL_W;

    logic [CNT_W-1:0] table_w [N_ENT];

    // Build one constant table entry for each code.
    for (genvar g = 0; g < N_ENT; g++) begin : g_ent
        assign table_w[g] = CNT_W'(refdiv_pkg::ratio_of(g) - 1);
    end

    // Select the entry for the present code.
    assign reload_o = table_w[sel_i];

endmodule

// File: rtl/refdiv_downcnt.sv
// Module: loadable down-counter that flags its terminal count.
// Assumes: reload_i is at least 1, so the flag never stays high for two cycles.
module refdiv_downcnt #(
    parameter int CNT_W = refdiv_pkg::CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] reload_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             tc_o
);

    logic [CNT_W-1:0] cnt_q;

    // Load on reset or at terminal count; otherwise count down by one.
    always_ff @(posedge clk) begin
        if (!rst_n || tc_o) begin
            cnt_q <= reload_i;
        end else begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // The terminal count is reached when the counter is zero.
    assign tc_o  = (cnt_q == '0);
    assign cnt_o = cnt_q;

endmodule

// File: rtl/refdiv.sv
// Module: top of the code-selected reference divider.
// It emits a one-cycle pulse every ratio(sel) clocks.
// Assumes: the select code is synchronous to clk and is sampled only on reset and at the terminal count.
module refdiv #(
    parameter int SEL_W = refdiv_pkg::SEL_W,
    parameter int CNT_W = refdiv_pkg::CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] ratio_sel,
    output logic             ref_pulse_o
);

    logic [CNT_W-1:0] reload_w;
    logic [CNT_W-1:0] cnt_q;
    logic             tc_w;

    // Ratio table lookup.
    refdiv_ratio_lut #(.SEL_W(SEL_W), .CNT_W(CNT_W)) lut_i (
        .sel_i    (ratio_sel),
        .reload_o (reload_w)
    );

    // Period counter.
    refdiv_downcnt #(.CNT_W(CNT_W)) cnt_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .reload_i (reload_w),
        .cnt_o    (cnt_q),
        .tc_o     (tc_w)
    );

    // The pulse is the terminal count of the period counter.
    assign ref_pulse_o = tc_w;

endmodule

// File: rtl/refdiv_chk.sv
// Module: assertion checker bound to refdiv.
// Assumes: it can observe the top's ports and the counter state cnt_q.
module refdiv_chk #(
    parameter int SEL_W = refdiv_pkg::SEL_W,
    parameter int CNT_W = refdiv_pkg::CNT_W
) (
    input logic             clk,
    input logic             rst_n,
    input logic [SEL_W-1:0] ratio_sel,
    input logic             ref_pulse_o,
    input logic [CNT_W-1:0] cnt_q
);

    localparam int MAX_GAP = 1 << (CNT_W - 1);

    logic       rst_seen_q;
    int unsigned gap_q;

    // Track that a reset edge has been sampled.
    always_ff @(posedge clk) begin
        rst_seen_q <= !rst_n;
    end

    // Count the cycles since the last pulse.
    always_ff @(posedge clk) begin
        if (!rst_n || ref_pulse_o) gap_q <= 0;
        else                       gap_q <= gap_q + 1;
    end

    // R6
    always_ff @(posedge clk) begin
        if (rst_seen_q && !rst_n) begin
            reset_quiet_chk: assert (!ref_pulse_o);
        end
    end

    // R3
    pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ref_pulse_o |=> !ref_pulse_o);

    // R2
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ref_pulse_o |=> cnt_q == $past(cnt_q) - 1'b1);

    // R4
    reload_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ref_pulse_o |=> cnt_q == CNT_W'(refdiv_pkg::ratio_of(int'($past(ratio_sel))) - 1));

    // R1
    max_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gap_q < MAX_GAP);

endmodule

bind refdiv refdiv_chk #(.SEL_W(SEL_W), .CNT_W(CNT_W)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .ratio_sel   (ratio_sel),
    .ref_pulse_o (ref_pulse_o),
    .cnt_q       (cnt_q)
);

// File: tb/refdiv_tb_top.sv
// Bench: sweeps every select code and the code-change corner cases.
// Expected periods are computed arithmetically in the bench.
module refdiv_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] ratio_sel = 3'd0;
    logic       ref_pulse_o;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    refdiv dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .ratio_sel   (ratio_sel),
        .ref_pulse_o (ref_pulse_o)
    );

    function automatic int exp_ratio(input int code);
        if (code == 6) return 2410;
        if (code == 0) return 8;
        return 1 << (code + 6);
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Count falling edges until the pulse is seen.
    task automatic wait_pulse(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!ref_pulse_o && n < 20000);
    endtask

    task automatic do_reset(input int code);
        @(negedge clk);
        ratio_sel = 3'(code);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk("R6 quiet in reset", int'(ref_pulse_o), 0);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int n;
        // R1 R2 R3 R6: every code
        for (int code = 0; code < 8; code++) begin
            do_reset(code);
            wait_pulse(n);
            chk("R6 first pulse", n, exp_ratio(code) - 1);
            @(negedge clk);
            chk("R3 pulse width", int'(ref_pulse_o), 0);
            wait_pulse(n);
            chk("R1 period", n + 1, exp_ratio(code));
            wait_pulse(n);
            chk("R2 repeated period", n, exp_ratio(code));
            if (code == 6) begin
                real f;
                f = 10.0417e6 / real'(n);
                chk("R8 comparison freq", int'((f > 4166.2) && (f < 4167.2)), 1);
            end
        end

        // R4: change in mid-period
        do_reset(0);
        wait_pulse(n);
        repeat (3) @(negedge clk);
        ratio_sel = 3'd2;
        wait_pulse(n);
        chk("R4 old ratio completes", n, 5);
        wait_pulse(n);
        chk("R4 new ratio next", n, 256);

        // R5: change and restore before the terminal count
        ratio_sel = 3'd3;
        wait_pulse(n);
        repeat (10) @(negedge clk);
        ratio_sel = 3'd7;
        repeat (10) @(negedge clk);
        ratio_sel = 3'd3;
        wait_pulse(n);
        chk("R5 running period kept", n, 492);
        wait_pulse(n);
        chk("R5 next period kept", n, 512);

        // R7: code set in the pulse cycle
        ratio_sel = 3'd1;
        wait_pulse(n);
        chk("R7 code at pulse", n, 128);
        ratio_sel = 3'd0;
        wait_pulse(n);
        chk("R7 code at pulse short", n, 8);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule